// File: doc/BRIEF.md
# Dual-User Protected Memory Router

This block sits in the data path between two 16-bit user buses and one memory bus. The memory bus carries 16 data bits together with a 6-bit check field. Each user can write a word to memory, read a word back, or hand a word straight to the other user without touching memory. When a user writes, the block computes the check field and sends it out with the data. When a user reads, the block checks the returned word, repairs a single flipped bit if correction is enabled, and returns the word to the requester with two error flags.

While one user owns a memory cycle, a listen input lets the other user receive a copy of the word that crosses the bus. Each bidirectional bus is modelled as an input port, an output port and an output enable. Every operation takes two clock edges. The first edge grants the operation and drives or reads the memory bus. The second edge presents the result on the user side.

User 1 has fixed priority. When both users ask in the same cycle, the request from user 2 is stored and served later.

Top module: `edac_dual_router`

## Requirements
- R1: While reset is high and after it is released, with no request made, every output is zero: `mem_oe`, `mem_rd`, `mem_dout`, both user output enables, both user data outputs and all four error flags.
- R2: Operation codes on `uN_op` are 0 write, 1 read, 2 transfer to the other user, 3 none. A write granted at clock edge k gives `mem_oe`=1 and `mem_dout`={check, data} after edge k. The check bits are `mem_dout[21:16]`. Check bit j is the XOR of the data bits whose column has bit j set. The column of data bit i is the i-th value, in ascending order, among the 6-bit values that have exactly three ones.
- R3: A read granted at edge k gives `mem_rd`=1 and `mem_oe`=0 after edge k. `mem_din` is sampled at edge k+1. After edge k+1 the owner's output enable is 1, and its data and flags hold the check result.
- R4: With `correct_en`=1 (sampled with the request), a single flipped bit is handled as follows. If it is a data bit, that bit is repaired. If it is a check bit, the data is returned as stored. In both cases `ce`=1 and `ue`=0.
- R5: When exactly two bits of the 22-bit word are flipped, the owner gets `ue`=1 and `ce`=0, and the data bits are returned as read, without repair.
- R6: With `correct_en`=0, a single flipped bit still raises `ce`, but the data bits are returned as read, without repair.
- R7: A transfer granted at edge k puts the sender's word on the other user's output, with its output enable high, after edge k+1. `mem_oe` and `mem_rd` stay low, and all four flags are low.
- R8: When `listen_en`=1 is sampled with a memory request, the other user gets the data after edge k+1. For a write this is the written data. For a read it is the checked result. The listener's flags stay low. With `listen_en`=0 the other user's output enable stays low.
- R9: When both users request in the same cycle, the user 1 operation is granted. The user 2 operation is stored and granted in the next cycle with no user 1 request, even if user 2 has dropped its request by then.
- R10: A request with operation code 3 has no effect. A user 2 request made in the same cycle is granted at once.
- R11: `mem_oe` and `mem_rd` are never high together. A user's output enable is never raised for its own write or transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| u1_req | input | 1 | User 1 request strobe |
| u1_op | input | 2 | User 1 operation code |
| u1_din | input | 16 | User 1 data towards the block |
| u1_dout | output | 16 | Data towards user 1 |
| u1_oe | output | 1 | Block drives user 1 bus |
| u1_ce | output | 1 | User 1 correctable error flag |
| u1_ue | output | 1 | User 1 uncorrectable error flag |
| u2_req | input | 1 | User 2 request strobe |
| u2_op | input | 2 | User 2 operation code |
| u2_din | input | 16 | User 2 data towards the block |
| u2_dout | output | 16 | Data towards user 2 |
| u2_oe | output | 1 | Block drives user 2 bus |
| u2_ce | output | 1 | User 2 correctable error flag |
| u2_ue | output | 1 | User 2 uncorrectable error flag |
| listen_en | input | 1 | Let the non-owner receive a copy of a memory cycle |
| correct_en | input | 1 | 1 repairs single-bit errors, 0 only flags them |
| mem_din | input | 22 | Word returned by memory |
| mem_dout | output | 22 | Word driven to memory |
| mem_oe | output | 1 | Block drives memory bus (write) |
| mem_rd | output | 1 | Memory is asked to drive the bus (read) |

## Verification
Two functions can fall in the same clock cycle: a user 1 request and a user 2 request. In that case the arbitration and the stored-request path act together. The bench provokes this by raising a user 1 write and a user 2 transfer together, then dropping both requests before the next edge. It judges the memory outputs after the first edge and the user 1 outputs two edges later. A second case pairs an ignored user 1 code with a user 2 write, and is judged on the memory bus. Exhaustive sweeps of every single-bit and every double-bit flip of the stored word cover the check path, and the expected data is computed from the injected flip mask.

// File: rtl/edac_router_pkg.sv
package edac_router_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_XFER  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    CMD_IDLE    = 3'd0,
    CMD_U1_WR   = 3'd1,
    CMD_U1_RD   = 3'd2,
    CMD_U2_WR   = 3'd3,
    CMD_U2_RD   = 3'd4,
    CMD_U1_XFER = 3'd5,
    CMD_U2_XFER = 3'd6
  } cmd_e;

  // Column of data bit idx: the idx-th r-bit value (ascending) with exactly three ones.
  function automatic logic [7:0] hsiao_col(input int r, input int idx);
    int n;
    n = 0;
    hsiao_col = '0;
    for (int v = 0; v < 256; v++) begin
      if (v < (1 << r) && $countones(v[7:0]) == 3) begin
        if (n == idx) hsiao_col = v[7:0];
        n++;
      end
    end
  endfunction

endpackage

// File: rtl/edac_encode.sv
module edac_encode #(
  parameter int DATA_W  = 16,
  parameter int CHECK_W = 6
) (
  input  logic [DATA_W-1:0]  data,
  output logic [CHECK_W-1:0] check
);
  logic [CHECK_W-1:0] contrib [DATA_W];

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [7:0] COL = edac_router_pkg::hsiao_col(CHECK_W, i);
    assign contrib[i] = data[i] ? COL[CHECK_W-1:0] : '0;
  end

  always_comb begin
    check = '0;
    for (int i = 0; i < DATA_W; i++) check = check ^ contrib[i];
  end
endmodule

// File: rtl/edac_decode.sv
module edac_decode #(
  parameter int DATA_W  = 16,
  parameter int CHECK_W = 6
) (
  input  logic [DATA_W-1:0]  data_in,
  input  logic [CHECK_W-1:0] check_in,
  input  logic               correct_en,
  output logic [DATA_W-1:0]  data_out,
  output logic               ce,
  output logic               ue
);
  logic [CHECK_W-1:0] recomputed;
  logic [CHECK_W-1:0] syndrome;
  logic [DATA_W-1:0]  hit;

  edac_encode #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) u_regen (
    .data  (data_in),
    .check (recomputed)
  );

  assign syndrome = recomputed ^ check_in;

  for (genvar i = 0; i < DATA_W; i++) begin : g_match
    localparam logic [7:0] COL = edac_router_pkg::hsiao_col(CHECK_W, i);
    assign hit[i] = (syndrome == COL[CHECK_W-1:0]);
  end

  always_comb begin
    data_out = correct_en ? (data_in ^ hit) : data_in;
    ce       = (|hit) || $onehot(syndrome);
    ue       = (syndrome != '0) && !ce;
  end
endmodule

// File: rtl/router_arbiter.sv
module router_arbiter
  import edac_router_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              u1_req,
  input  logic [1:0]        u1_op,
  input  logic [DATA_W-1:0] u1_din,
  input  logic              u2_req,
  input  logic [1:0]        u2_op,
  input  logic [DATA_W-1:0] u2_din,
  output cmd_e              grant_cmd,
  output logic [DATA_W-1:0] grant_data
);
  logic              hold_v;
  op_e               hold_op;
  logic [DATA_W-1:0] hold_data;
  logic              u1_act, u2_new, u2_want;
  op_e               u2_op_eff;
  logic [DATA_W-1:0] u2_d_eff;

  always_comb begin
    u1_act    = u1_req && (op_e'(u1_op) != OP_NONE);
    u2_new    = u2_req && (op_e'(u2_op) != OP_NONE);
    u2_want   = hold_v || u2_new;
    u2_op_eff = hold_v ? hold_op : op_e'(u2_op);
    u2_d_eff  = hold_v ? hold_data : u2_din;
    grant_cmd = CMD_IDLE;
    if (u1_act) begin
      case (op_e'(u1_op))
        OP_WRITE: grant_cmd = CMD_U1_WR;
        OP_READ:  grant_cmd = CMD_U1_RD;
        OP_XFER:  grant_cmd = CMD_U1_XFER;
        default:  grant_cmd = CMD_IDLE;
      endcase
    end else if (u2_want) begin
      case (u2_op_eff)
        OP_WRITE: grant_cmd = CMD_U2_WR;
        OP_READ:  grant_cmd = CMD_U2_RD;
        OP_XFER:  grant_cmd = CMD_U2_XFER;
        default:  grant_cmd = CMD_IDLE;
      endcase
    end
    grant_data = u1_act ? u1_din : u2_d_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      hold_op   <= OP_NONE;
      hold_data <= '0;
    end else if (u1_act && u2_want) begin
      hold_v <= 1'b1;
      if (!hold_v) begin
        hold_op   <= op_e'(u2_op);
        hold_data <= u2_din;
      end
    end else begin
      hold_v <= 1'b0;
    end
  end

  // R9: a stored user 2 request leaves the store once user 1 is quiet
  assert_hold_release_R9: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !u1_act) |=> !hold_v);

  // R9: a user 1 request never leaves a pending user 2 request behind unstored
  assert_hold_capture_R9: assert property (@(posedge clk) disable iff (rst)
    (u1_act && u2_new) |=> hold_v);
endmodule

// File: rtl/edac_dual_router.sv
module edac_dual_router
  import edac_router_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CHECK_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      u1_req,
  input  logic [1:0]                u1_op,
  input  logic [DATA_W-1:0]         u1_din,
  output logic [DATA_W-1:0]         u1_dout,
  output logic                      u1_oe,
  output logic                      u1_ce,
  output logic                      u1_ue,
  input  logic                      u2_req,
  input  logic [1:0]                u2_op,
  input  logic [DATA_W-1:0]         u2_din,
  output logic [DATA_W-1:0]         u2_dout,
  output logic                      u2_oe,
  output logic                      u2_ce,
  output logic                      u2_ue,
  input  logic                      listen_en,
  input  logic                      correct_en,
  input  logic [DATA_W+CHECK_W-1:0] mem_din,
  output logic [DATA_W+CHECK_W-1:0] mem_dout,
  output logic                      mem_oe,
  output logic                      mem_rd
);
  localparam int MEM_W = DATA_W + CHECK_W;

  cmd_e               grant_cmd;
  logic [DATA_W-1:0]  grant_data;
  logic [CHECK_W-1:0] enc_check;
  cmd_e               s1_cmd;
  logic [DATA_W-1:0]  s1_data;
  logic               s1_listen;
  logic               s1_corr;
  logic [DATA_W-1:0]  dec_data;
  logic               dec_ce, dec_ue;
  logic               is_wr, is_rd;

  router_arbiter #(.DATA_W(DATA_W)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .u1_req     (u1_req),
    .u1_op      (u1_op),
    .u1_din     (u1_din),
    .u2_req     (u2_req),
    .u2_op      (u2_op),
    .u2_din     (u2_din),
    .grant_cmd  (grant_cmd),
    .grant_data (grant_data)
  );

  edac_encode #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) u_enc (
    .data  (grant_data),
    .check (enc_check)
  );

  edac_decode #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) u_dec (
    .data_in    (mem_din[DATA_W-1:0]),
    .check_in   (mem_din[MEM_W-1:DATA_W]),
    .correct_en (s1_corr),
    .data_out   (dec_data),
    .ce         (dec_ce),
    .ue         (dec_ue)
  );

  assign is_wr = (grant_cmd == CMD_U1_WR) || (grant_cmd == CMD_U2_WR);
  assign is_rd = (grant_cmd == CMD_U1_RD) || (grant_cmd == CMD_U2_RD);

  // Stage 1: grant, memory bus access
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_cmd    <= CMD_IDLE;
      s1_data   <= '0;
      s1_listen <= 1'b0;
      s1_corr   <= 1'b0;
      mem_oe    <= 1'b0;
      mem_rd    <= 1'b0;
      mem_dout  <= '0;
    end else begin
      s1_cmd    <= grant_cmd;
      s1_data   <= grant_data;
      s1_listen <= listen_en;
      s1_corr   <= correct_en;
      mem_oe    <= is_wr;
      mem_rd    <= is_rd;
      if (is_wr) mem_dout <= {enc_check, grant_data};
    end
  end

  // Stage 2: user side results
  always_ff @(posedge clk) begin
    if (rst) begin
      u1_dout <= '0;
      u2_dout <= '0;
      u1_oe   <= 1'b0;
      u2_oe   <= 1'b0;
      u1_ce   <= 1'b0;
      u1_ue   <= 1'b0;
      u2_ce   <= 1'b0;
      u2_ue   <= 1'b0;
    end else begin
      u1_oe <= 1'b0;
      u2_oe <= 1'b0;
      u1_ce <= 1'b0;
      u1_ue <= 1'b0;
      u2_ce <= 1'b0;
      u2_ue <= 1'b0;
      case (s1_cmd)
        CMD_U1_WR: if (s1_listen) begin
          u2_oe   <= 1'b1;
          u2_dout <= s1_data;
        end
        CMD_U2_WR: if (s1_listen) begin
          u1_oe   <= 1'b1;
          u1_dout <= s1_data;
        end
        CMD_U1_RD: begin
          u1_oe   <= 1'b1;
          u1_dout <= dec_data;
          u1_ce   <= dec_ce;
          u1_ue   <= dec_ue;
          if (s1_listen) begin
            u2_oe   <= 1'b1;
            u2_dout <= dec_data;
          end
        end
        CMD_U2_RD: begin
          u2_oe   <= 1'b1;
          u2_dout <= dec_data;
          u2_ce   <= dec_ce;
          u2_ue   <= dec_ue;
          if (s1_listen) begin
            u1_oe   <= 1'b1;
            u1_dout <= dec_data;
          end
        end
        CMD_U1_XFER: begin
          u2_oe   <= 1'b1;
          u2_dout <= s1_data;
        end
        CMD_U2_XFER: begin
          u1_oe   <= 1'b1;
          u1_dout <= s1_data;
        end
        default: ;
      endcase
    end
  end

  // R11: only one side drives the memory bus
  assert_single_mem_driver_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_oe && mem_rd));

  // R11: a user never receives its own write or transfer
  assert_owner_oe_u1_R11: assert property (@(posedge clk) disable iff (rst)
    (s1_cmd == CMD_U1_WR || s1_cmd == CMD_U1_XFER) |=> !u1_oe);
  assert_owner_oe_u2_R11: assert property (@(posedge clk) disable iff (rst)
    (s1_cmd == CMD_U2_WR || s1_cmd == CMD_U2_XFER) |=> !u2_oe);

  // R7: transfers leave memory idle and raise no flag
  assert_xfer_no_mem_R7: assert property (@(posedge clk) disable iff (rst)
    (s1_cmd == CMD_U1_XFER || s1_cmd == CMD_U2_XFER) |-> (!mem_oe && !mem_rd));
  assert_xfer_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (s1_cmd == CMD_U1_XFER || s1_cmd == CMD_U2_XFER) |=>
      !(u1_ce || u1_ue || u2_ce || u2_ue));

  // R5: the two flags never appear together
  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(u1_ce && u1_ue) && !(u2_ce && u2_ue));

  // R3: flags only accompany a returned word
  assert_flag_needs_oe_R3: assert property (@(posedge clk) disable iff (rst)
    ((u1_ce || u1_ue) |-> u1_oe) and ((u2_ce || u2_ue) |-> u2_oe));
endmodule

// File: tb/tb_edac_dual_router.sv
`timescale 1ns/1ps
module tb_edac_dual_router;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic u1_req = 1'b0, u2_req = 1'b0;
  logic [1:0] u1_op = 2'd3, u2_op = 2'd3;
  logic [15:0] u1_din = '0, u2_din = '0;
  logic [15:0] u1_dout, u2_dout;
  logic u1_oe, u1_ce, u1_ue, u2_oe, u2_ce, u2_ue;
  logic listen_en = 1'b0, correct_en = 1'b1;
  logic [21:0] mem_din = '0;
  logic [21:0] mem_dout;
  logic mem_oe, mem_rd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic snap_oe, snap_rd;
  logic [21:0] snap_dout;

  edac_dual_router dut (
    .clk(clk), .rst(rst),
    .u1_req(u1_req), .u1_op(u1_op), .u1_din(u1_din), .u1_dout(u1_dout),
    .u1_oe(u1_oe), .u1_ce(u1_ce), .u1_ue(u1_ue),
    .u2_req(u2_req), .u2_op(u2_op), .u2_din(u2_din), .u2_dout(u2_dout),
    .u2_oe(u2_oe), .u2_ce(u2_ce), .u2_ue(u2_ue),
    .listen_en(listen_en), .correct_en(correct_en),
    .mem_din(mem_din), .mem_dout(mem_dout), .mem_oe(mem_oe), .mem_rd(mem_rd)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Column of data bit i: i-th ascending 6-bit value with three ones (R2).
  function automatic logic [5:0] column(input int i);
    int n = 0;
    column = '0;
    for (int v = 0; v < 64; v++) begin
      int w = 0;
      for (int b = 0; b < 6; b++) w += (v >> b) & 1;
      if (w == 3) begin
        if (n == i) column = v[5:0];
        n++;
      end
    end
  endfunction

  function automatic logic [5:0] enc(input logic [15:0] d);
    enc = '0;
    for (int i = 0; i < 16; i++) if (d[i]) enc ^= column(i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request set, wait one edge (snapshot memory side), then the next edge.
  task automatic exec(input logic r1, input logic [1:0] o1, input logic [15:0] d1,
                      input logic r2, input logic [1:0] o2, input logic [15:0] d2,
                      input logic lis, input logic corr, input logic [21:0] mw);
    u1_req = r1; u1_op = o1; u1_din = d1;
    u2_req = r2; u2_op = o2; u2_din = d2;
    listen_en = lis; correct_en = corr; mem_din = mw;
    @(negedge clk);
    snap_oe = mem_oe; snap_rd = mem_rd; snap_dout = mem_dout;
    u1_req = 1'b0; u2_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    logic [21:0] word, mask;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 mem_oe", 32'(mem_oe), 0);
    chk("R1 mem_rd", 32'(mem_rd), 0);
    chk("R1 mem_dout", 32'(mem_dout), 0);
    chk("R1 user oe", {30'd0, u1_oe, u2_oe}, 0);
    chk("R1 flags", {28'd0, u1_ce, u1_ue, u2_ce, u2_ue}, 0);
    chk("R1 douts", {u1_dout, u2_dout}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {27'd0, mem_oe, mem_rd, u1_oe, u2_oe, u1_ce}, 0);

    // R2 / R8 / R11: writes from both users, listen on and off
    for (int k = 0; k < 24; k++) begin
      logic own1, lis;
      d = 16'((k * 16'h2F39) ^ (16'h1 << (k % 16)));
      own1 = (k % 2) == 0;
      lis = (k % 4) < 2;
      if (own1) exec(1, 2'd0, d, 0, 2'd3, 16'h0, lis, 1, 22'h0);
      else      exec(0, 2'd3, 16'h0, 1, 2'd0, d, lis, 1, 22'h0);
      chk("R2 write mem_oe", 32'(snap_oe), 1);
      chk("R11 write mem_rd", 32'(snap_rd), 0);
      chk("R2 write word", 32'(snap_dout), 32'({enc(d), d}));
      chk("R11 owner oe on own write", 32'(own1 ? u1_oe : u2_oe), 0);
      chk("R8 listener oe", 32'(own1 ? u2_oe : u1_oe), 32'(lis));
      if (lis) begin
        chk("R8 listener data", 32'(own1 ? u2_dout : u1_dout), 32'(d));
        chk("R8 listener flags", 32'(own1 ? {u2_ce, u2_ue} : {u1_ce, u1_ue}), 0);
      end
    end

    // R3: clean reads
    for (int k = 0; k < 8; k++) begin
      d = 16'(16'hA5C3 + k * 16'h1357);
      exec(k % 2 == 0, 2'd1, 16'h0, k % 2 == 1, 2'd1, 16'h0, 0, 1, {enc(d), d});
      chk("R3 read mem_rd", 32'(snap_rd), 1);
      chk("R3 read mem_oe", 32'(snap_oe), 0);
      if (k % 2 == 0) begin
        chk("R3 read u1", {13'd0, u1_oe, u1_ce, u1_ue, u1_dout}, {13'd0, 3'b100, d});
        chk("R8 no listen u2", 32'(u2_oe), 0);
      end else begin
        chk("R3 read u2", {13'd0, u2_oe, u2_ce, u2_ue, u2_dout}, {13'd0, 3'b100, d});
        chk("R8 no listen u1", 32'(u1_oe), 0);
      end
    end

    // R4: every single flip, correction on, user 1
    d = 16'h3C96;
    for (int p = 0; p < 22; p++) begin
      mask = 22'(1) << p;
      exec(1, 2'd1, 16'h0, 0, 2'd3, 16'h0, 0, 1, {enc(d), d} ^ mask);
      chk("R4 single corrected data", 32'(u1_dout), 32'(d));
      chk("R4 single flags", {30'd0, u1_ce, u1_ue}, 32'b10);
    end

    // R6: every single flip, correction off, user 2
    d = 16'hE01B;
    for (int p = 0; p < 22; p++) begin
      mask = 22'(1) << p;
      exec(0, 2'd3, 16'h0, 1, 2'd1, 16'h0, 0, 0, {enc(d), d} ^ mask);
      chk("R6 detect-only data", 32'(u2_dout), 32'(d ^ mask[15:0]));
      chk("R6 detect-only flags", {30'd0, u2_ce, u2_ue}, 32'b10);
    end

    // R5: every double flip
    d = 16'h5AF0;
    for (int a = 0; a < 22; a++) begin
      for (int b = a + 1; b < 22; b++) begin
        mask = (22'(1) << a) | (22'(1) << b);
        exec(1, 2'd1, 16'h0, 0, 2'd3, 16'h0, 0, 1, {enc(d), d} ^ mask);
        chk("R5 double data", 32'(u1_dout), 32'(d ^ mask[15:0]));
        chk("R5 double flags", {30'd0, u1_ce, u1_ue}, 32'b01);
      end
    end

    // R8: listened read gets corrected word, no flags
    d = 16'h7711;
    exec(1, 2'd1, 16'h0, 0, 2'd3, 16'h0, 1, 1, {enc(d), d} ^ 22'h000020);
    chk("R8 listen read data", 32'(u2_dout), 32'(d));
    chk("R8 listen read oe/flags", {29'd0, u2_oe, u2_ce, u2_ue}, 32'b100);
    chk("R4 owner flag with listener", 32'(u1_ce), 1);

    // R7: transfers both ways
    exec(1, 2'd2, 16'hBEEF, 0, 2'd3, 16'h0, 1, 1, 22'h0);
    chk("R7 u1->u2 memory idle", {30'd0, snap_oe, snap_rd}, 0);
    chk("R7 u1->u2 data", {15'd0, u2_oe, u2_dout}, {15'd0, 1'b1, 16'hBEEF});
    chk("R7 u1->u2 flags/owner oe", {27'd0, u1_oe, u1_ce, u1_ue, u2_ce, u2_ue}, 0);
    exec(0, 2'd3, 16'h0, 1, 2'd2, 16'h1234, 0, 1, 22'h0);
    chk("R7 u2->u1 memory idle", {30'd0, snap_oe, snap_rd}, 0);
    chk("R7 u2->u1 data", {15'd0, u1_oe, u1_dout}, {15'd0, 1'b1, 16'h1234});
    chk("R7 u2->u1 flags/owner oe", {27'd0, u2_oe, u1_ce, u1_ue, u2_ce, u2_ue}, 0);

    // R10: ignored code 3 alongside a user 2 write
    exec(1, 2'd3, 16'hFFFF, 1, 2'd0, 16'h0F0F, 0, 1, 22'h0);
    chk("R10 u2 granted at once", 32'(snap_oe), 1);
    chk("R10 u2 word", 32'(snap_dout), 32'({enc(16'h0F0F), 16'h0F0F}));
    exec(1, 2'd3, 16'hFFFF, 0, 2'd3, 16'h0, 1, 1, 22'h0);
    chk("R10 code 3 alone no effect",
        {26'd0, snap_oe, snap_rd, u1_oe, u2_oe, u1_ce, u2_ce}, 0);

    // R9: contention, user 2 drops its request after one cycle
    u1_req = 1; u1_op = 2'd0; u1_din = 16'hC001;
    u2_req = 1; u2_op = 2'd2; u2_din = 16'hD00D;
    listen_en = 0; correct_en = 1;
    @(negedge clk);
    chk("R9 u1 wins first", 32'(mem_oe), 1);
    chk("R9 u1 word", 32'(mem_dout), 32'({enc(16'hC001), 16'hC001}));
    u1_req = 0; u2_req = 0; u2_din = 16'h0000;
    @(negedge clk);
    chk("R9 held transfer uses no memory", {30'd0, mem_oe, mem_rd}, 0);
    chk("R11 u1 oe after own write", 32'(u1_oe), 0);
    @(negedge clk);
    chk("R9 held transfer delivered", {15'd0, u1_oe, u1_dout}, {15'd0, 1'b1, 16'hD00D});
    @(negedge clk);
    chk("R9 served once", 32'(u1_oe), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule